// File: doc/BRIEF.md
# Wake Cause Capture Register

This block records which event brought the device out of its deepest low-power state. Each wake source has its own synchronous, active-high input. Those sources are an external pin-change interrupt, a supply fault, an ultra-low-power analog wake, a low-power watchdog timeout, a calendar alarm, an external reset pin and a supply power-on reset. A `sleep_active` input marks the deep-sleep episode. Within an episode, only the first wake source to be seen is latched. Every later source is ignored until the episode ends and a new one begins.

Firmware reads the result through a byte-wide register port, which selects either the high or the low status byte. The same port clears the flags by writing zeros. It can also set flags by writing ones, which lets firmware test its handlers. The power-on reset flag is the one exception to the deep-sleep qualification. It is set whenever a supply power-on reset is detected, and it comes out of reset already set.

Top module: `wake_cause_reg`

## Requirements
- R1: After reset, the low byte reads 0x01 (only the power-on flag set) and the high byte reads 0x00.
- R2: Unimplemented bits read as 0, and writes to them have no effect. In the high byte these are bits 7..1. In the low byte they are bits 6 and 1.
- R3: Low byte (reg_sel_hi=0) bit positions: bit 7 fault, bit 5 ultra-low-power wake, bit 4 watchdog timeout, bit 3 calendar alarm, bit 2 reset-pin event, bit 0 power-on event.
- R4: High byte (reg_sel_hi=1) bit 0 is the pin-change interrupt flag.
- R5: No wake flag other than the power-on flag is set by a source while `sleep_active` is 0.
- R6: A high `ev_por` sets the power-on flag whether or not `sleep_active` is high.
- R7: Within one deep-sleep episode, only the first cycle in which any qualified source is high sets a flag. Sources that rise in later cycles are ignored.
- R8: When several sources are high in that first cycle, one flag is set. The winner follows a fixed priority: fault, reset pin, watchdog, alarm, ultra-low-power, pin-change interrupt.
- R9: After a capture, capture stays locked until `sleep_active` has been low for at least one clock and is then high again.
- R10: A register write loads every implemented bit of the selected byte. Writing 0 clears a flag and writing 1 sets it.
- R11: If a hardware capture and a register write hit the same flag in the same cycle, the flag ends up set.
- R12: A flag appears in `reg_rdata` one clock after its source is sampled high. The read path is combinational from the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep_active | input | 1 | High while the device is in a deep-sleep episode |
| ev_fault | input | 1 | Supply fault wake source |
| ev_pin_reset | input | 1 | External reset-pin wake source |
| ev_wdt | input | 1 | Low-power watchdog timeout wake source |
| ev_alarm | input | 1 | Calendar alarm wake source |
| ev_ulp | input | 1 | Ultra-low-power wake source |
| ev_ioc | input | 1 | Pin-change interrupt wake source |
| ev_por | input | 1 | Supply power-on reset detected |
| reg_sel_hi | input | 1 | Byte select: 1 selects the high byte, 0 the low byte |
| reg_wr | input | 1 | Write strobe for the selected byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected byte |

## Verification
The assertions check several rules on every cycle:
- no new source flag appears while awake or while capture is locked, unless a write occurs;
- a power-on event always leaves its flag set;
- a hardware grant is never lost to a concurrent write;
- at most one grant is issued at a time;
- unimplemented bits read as zero.

Some behaviour can only be shown by the directed scenarios: the exact bit positions of each source, which source wins a tie, that capture re-arms only after sleep has been dropped and raised again, and the one-cycle latency from source to read data.

// File: rtl/wake_cause_pkg.sv
package wake_cause_pkg;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_SRC = 6;

  // Source index doubles as arbitration rank: lower index wins.
  localparam int unsigned IDX_FAULT = 0;
  localparam int unsigned IDX_PIN   = 1;
  localparam int unsigned IDX_WDT   = 2;
  localparam int unsigned IDX_ALARM = 3;
  localparam int unsigned IDX_ULP   = 4;
  localparam int unsigned IDX_IOC   = 5;

  localparam int unsigned POR_BIT = 0;

  localparam logic [REG_W-1:0] LO_IMPL_MASK = 8'hBD;
  localparam logic [REG_W-1:0] HI_IMPL_MASK = 8'h01;

  // Which status byte holds a given source flag.
  function automatic logic src_in_hi(input int unsigned idx);
    return (idx == IDX_IOC);
  endfunction

  // Bit position of a source flag within its byte.
  function automatic int unsigned src_bit(input int unsigned idx);
    int unsigned pos;
    case (idx)
      IDX_FAULT: pos = 7;
      IDX_PIN:   pos = 2;
      IDX_WDT:   pos = 4;
      IDX_ALARM: pos = 3;
      IDX_ULP:   pos = 5;
      default:   pos = 0;
    endcase
    return pos;
  endfunction

endpackage

// File: rtl/wake_arbiter.sv
module wake_arbiter
  import wake_cause_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep_active,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         locked
);

  logic         locked_q;
  logic         locked_d;
  logic [N-1:0] qual;
  logic         any_grant;

  // Requests only count inside an unlocked episode.
  always_comb begin
    qual = (sleep_active && !locked_q) ? req : '0;
  end

  // Fixed priority: lowest index wins.
  always_comb begin
    logic seen;
    seen  = 1'b0;
    grant = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (qual[i] && !seen) begin
        grant[i] = 1'b1;
      end
      seen = seen | qual[i];
    end
  end

  assign any_grant = |grant;

  // The lock drops whenever sleep is low and is set by a grant.
  always_comb begin
    locked_d = locked_q;
    if (!sleep_active) begin
      locked_d = 1'b0;
    end else if (any_grant) begin
      locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
    end else begin
      locked_q <= locked_d;
    end
  end

  assign locked = locked_q;

  // R8: never more than one source granted in a cycle
  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9: a grant in a sleeping cycle leaves capture locked
  a_r9_lock_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (any_grant && sleep_active) |=> locked);

endmodule

// File: rtl/wake_flag_bank.sv
module wake_flag_bank
  import wake_cause_pkg::*;
#(
  parameter int unsigned N = NUM_SRC,
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic         por_event,
  input  logic         wr_en,
  input  logic         wr_sel_hi,
  input  logic [W-1:0] wdata,
  output logic [N-1:0] flags,
  output logic         por_flag
);

  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;
  logic         por_q;
  logic         por_d;

  for (genvar g = 0; g < int'(N); g++) begin : g_flag
    localparam logic        IN_HI = src_in_hi(g);
    localparam int unsigned POS   = src_bit(g);
    logic wr_hit;

    assign wr_hit = wr_en && (wr_sel_hi == IN_HI);

    // A hardware set takes precedence over a software write.
    always_comb begin
      flags_d[g] = flags_q[g];
      if (hw_set[g]) begin
        flags_d[g] = 1'b1;
      end else if (wr_hit) begin
        flags_d[g] = wdata[POS];
      end
    end
  end

  always_comb begin
    por_d = por_q;
    if (por_event) begin
      por_d = 1'b1;
    end else if (wr_en && !wr_sel_hi) begin
      por_d = wdata[POR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      por_q   <= 1'b1;
    end else begin
      flags_q <= flags_d;
      por_q   <= por_d;
    end
  end

  assign flags    = flags_q;
  assign por_flag = por_q;

  // R6: a power-on event always leaves its flag set
  a_r6_por_sets: assert property (@(posedge clk) disable iff (!rst_n)
    por_event |=> por_flag);

  // R11: a hardware set is never lost to a concurrent write
  a_r11_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((flags & $past(hw_set)) == $past(hw_set)));

endmodule

// File: rtl/wake_read_mux.sv
module wake_read_mux
  import wake_cause_pkg::*;
#(
  parameter int unsigned N = NUM_SRC,
  parameter int unsigned W = REG_W
) (
  input  logic [N-1:0] flags,
  input  logic         por_flag,
  input  logic         sel_hi,
  output logic [W-1:0] rdata
);

  logic [W-1:0] lo_byte;
  logic [W-1:0] hi_byte;

  always_comb begin
    lo_byte          = '0;
    hi_byte          = '0;
    lo_byte[POR_BIT] = por_flag;
    for (int unsigned i = 0; i < N; i++) begin
      if (src_in_hi(i)) begin
        hi_byte[src_bit(i)] = flags[i];
      end else begin
        lo_byte[src_bit(i)] = flags[i];
      end
    end
  end

  assign rdata = sel_hi ? hi_byte : lo_byte;

endmodule

// File: rtl/wake_cause_reg.sv
module wake_cause_reg
  import wake_cause_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_active,
  input  logic       ev_fault,
  input  logic       ev_pin_reset,
  input  logic       ev_wdt,
  input  logic       ev_alarm,
  input  logic       ev_ulp,
  input  logic       ev_ioc,
  input  logic       ev_por,
  input  logic       reg_sel_hi,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);

  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] flags;
  logic               por_flag;
  logic               locked;

  // Request vector in arbitration order.
  always_comb begin
    req            = '0;
    req[IDX_FAULT] = ev_fault;
    req[IDX_PIN]   = ev_pin_reset;
    req[IDX_WDT]   = ev_wdt;
    req[IDX_ALARM] = ev_alarm;
    req[IDX_ULP]   = ev_ulp;
    req[IDX_IOC]   = ev_ioc;
  end

  wake_arbiter #(.N(NUM_SRC)) arb_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_active (sleep_active),
    .req          (req),
    .grant        (grant),
    .locked       (locked)
  );

  wake_flag_bank #(.N(NUM_SRC), .W(REG_W)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_set    (grant),
    .por_event (ev_por),
    .wr_en     (reg_wr),
    .wr_sel_hi (reg_sel_hi),
    .wdata     (reg_wdata),
    .flags     (flags),
    .por_flag  (por_flag)
  );

  wake_read_mux #(.N(NUM_SRC), .W(REG_W)) mux_i (
    .flags    (flags),
    .por_flag (por_flag),
    .sel_hi   (reg_sel_hi),
    .rdata    (reg_rdata)
  );

  // R5: awake and no write means no new source flag
  a_r5_awake_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_active && !reg_wr) |=> ((flags & ~$past(flags)) == '0));

  // R7: a locked episode gains no new source flag
  a_r7_locked_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !reg_wr) |=> ((flags & ~$past(flags)) == '0));

  // R2: unimplemented bits always read zero
  a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~(reg_sel_hi ? HI_IMPL_MASK : LO_IMPL_MASK)) == '0);

endmodule

// File: tb/wake_cause_reg_tb_top.sv
module wake_cause_reg_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sleep_active;
  logic [5:0] src;  // 0 fault, 1 pin, 2 wdt, 3 alarm, 4 ulp, 5 ioc
  logic       ev_por;
  logic       reg_sel_hi;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  wake_cause_reg dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_active (sleep_active),
    .ev_fault     (src[0]),
    .ev_pin_reset (src[1]),
    .ev_wdt       (src[2]),
    .ev_alarm     (src[3]),
    .ev_ulp       (src[4]),
    .ev_ioc       (src[5]),
    .ev_por       (ev_por),
    .reg_sel_hi   (reg_sel_hi),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_lo(input logic [5:0] m, input logic por);
    return {m[0], 1'b0, m[4], m[2], m[3], m[1], 1'b0, por};
  endfunction

  function automatic logic [7:0] exp_hi(input logic [5:0] m);
    return {7'b0, m[5]};
  endfunction

  task automatic rd(input logic hi, output logic [7:0] v);
    @(negedge clk);
    reg_sel_hi = hi;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic hi, input logic [7:0] d);
    @(negedge clk);
    reg_sel_hi = hi;
    reg_wdata  = d;
    reg_wr     = 1'b1;
    @(negedge clk);
    reg_wr     = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] m);
    @(negedge clk);
    src = m;
    @(negedge clk);
    src = '0;
  endtask

  task automatic new_episode();
    @(negedge clk);
    sleep_active = 1'b0;
    @(negedge clk);
    sleep_active = 1'b1;
  endtask

  task automatic clear_all();
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v); check("R1 low byte after reset", v, 8'h01);
    rd(1'b1, v); check("R1 high byte after reset", v, 8'h00);
  endtask

  task automatic t_single_sources();
    logic [7:0] v;
    for (int i = 0; i < 6; i++) begin
      logic [5:0] m;
      logic       hi;
      m  = 6'(1 << i);
      hi = (i == 5);
      clear_all();
      new_episode();
      @(negedge clk);
      reg_sel_hi = hi;
      src = m;
      #1 check("R12 flag not yet visible", reg_rdata, 8'h00);
      @(posedge clk);
      #1 check(hi ? "R4 R12 pin-change flag in high byte" : "R3 R12 low byte position",
               reg_rdata, hi ? exp_hi(m) : exp_lo(m, 1'b0));
      @(negedge clk);
      src = '0;
      rd(~hi, v);
      check("R3 R4 other byte untouched", v, 8'h00);
    end
  endtask

  task automatic t_first_wins();
    logic [7:0] v;
    clear_all();
    new_episode();
    pulse(6'b000100);
    pulse(6'b000001);
    pulse(6'b100000);
    rd(1'b0, v); check("R7 first source only, low", v, 8'h10);
    rd(1'b1, v); check("R7 later pin-change ignored", v, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    clear_all(); new_episode();
    pulse(6'b111000);
    rd(1'b0, v); check("R8 alarm beats ulp and ioc", v, 8'h08);
    rd(1'b1, v); check("R8 ioc loses tie", v, 8'h00);
    clear_all(); new_episode();
    pulse(6'b111111);
    rd(1'b0, v); check("R8 fault beats all", v, 8'h80);
    clear_all(); new_episode();
    pulse(6'b000110);
    rd(1'b0, v); check("R8 pin beats watchdog", v, 8'h04);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    clear_all(); new_episode();
    pulse(6'b010000);
    pulse(6'b000001);
    rd(1'b0, v); check("R9 locked after ulp capture", v, 8'h20);
    @(negedge clk); sleep_active = 1'b0;
    @(negedge clk); sleep_active = 1'b1;
    pulse(6'b100000);
    rd(1'b1, v); check("R9 re-armed after sleep toggle", v, 8'h01);
    rd(1'b0, v); check("R9 earlier flag kept", v, 8'h20);
  endtask

  task automatic t_awake();
    logic [7:0] v;
    clear_all();
    @(negedge clk); sleep_active = 1'b0;
    pulse(6'b111111);
    rd(1'b0, v); check("R5 no low capture when awake", v, 8'h00);
    rd(1'b1, v); check("R5 no high capture when awake", v, 8'h00);
  endtask

  task automatic t_por();
    logic [7:0] v;
    @(negedge clk); sleep_active = 1'b0; ev_por = 1'b1;
    @(negedge clk); ev_por = 1'b0;
    rd(1'b0, v); check("R6 power-on flag while awake", v, 8'h01);
    clear_all(); new_episode();
    pulse(6'b001000);
    @(negedge clk); ev_por = 1'b1;
    @(negedge clk); ev_por = 1'b0;
    rd(1'b0, v); check("R6 power-on flag while locked", v, 8'h09);
  endtask

  task automatic t_write();
    logic [7:0] v;
    clear_all();
    @(negedge clk); sleep_active = 1'b0;
    wr(1'b0, 8'hFF);
    rd(1'b0, v); check("R2 R10 low byte write ones", v, 8'hBD);
    wr(1'b1, 8'hFF);
    rd(1'b1, v); check("R2 R10 high byte write ones", v, 8'h01);
    wr(1'b0, 8'h42);
    rd(1'b0, v); check("R2 R10 partial write", v, 8'h00);
    wr(1'b1, 8'h00);
    rd(1'b1, v); check("R10 high byte cleared", v, 8'h00);
  endtask

  task automatic t_hw_wins();
    logic [7:0] v;
    wr(1'b0, 8'h80);
    new_episode();
    @(negedge clk);
    reg_sel_hi = 1'b0;
    reg_wdata  = 8'h00;
    reg_wr     = 1'b1;
    src        = 6'b001000;
    @(negedge clk);
    reg_wr = 1'b0;
    src    = '0;
    rd(1'b0, v); check("R11 capture beats write clear", v, 8'h08);
  endtask

  initial begin
    rst_n        = 1'b0;
    sleep_active = 1'b0;
    src          = '0;
    ev_por       = 1'b0;
    reg_sel_hi   = 1'b0;
    reg_wr       = 1'b0;
    reg_wdata    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_sources();
    t_first_wins();
    t_priority();
    t_lock();
    t_awake();
    t_por();
    t_write();
    t_hw_wins();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule